// File: doc/BRIEF.md
# Byte-Lane Reordering Aligner

This block sits behind a deserializer that has already found symbol boundaries but not word boundaries. Each receive word carries four bytes, and each byte has its own control-character flag. A transmitted word can therefore arrive split across two received words, shifted by zero to three byte lanes. The block looks for a control-flagged marker byte (value 0x1C with its flag set). It records the lane where the marker sits and from then on rebuilds every output word from the tail of the previous input word and the head of the current one.

The search is manual. It runs only while the user's alignment enable is high and the upstream sync status is asserted. The user raises the enable while the transmitter sends its alignment word, whose byte 0 is the control byte 0x1C, whose byte 1 is the control byte 0xBC, and whose upper two bytes are plain zeros. After lock, the marker lands in output lane 0 and the 0xBC in lane 1. The chosen shift is kept until a new search finds a marker. If sync status is lost, the lock indicator drops and the block goes back to searching.

Top module: `byte_lane_aligner`

## Requirements
- R1: While synchronous reset is applied and in the cycle after it is released, `locked` is 0, `offset` is 0 and `out_valid` is 0.
- R2: A lane matches the marker only when its control flag bit is 1 and its byte equals 0x1C. A 0x1C with a clear flag does not match, and neither does any other flagged byte (0xBC, 0x1D, 0x9C).
- R3: No lock is taken from a word presented while `sync_ok` is 0.
- R4: No lock is taken from a word presented while `align_en` is 0, and `locked` only rises after a cycle in which both `sync_ok` and `align_en` were 1.
- R5: When several lanes of one word match, the lowest lane index becomes the offset.
- R6: At the clock edge that samples a matching word with `sync_ok` and `align_en` both high, `offset` becomes the marker's lane index (lane l occupies bits 8l+7..8l of `rx_data` and bit l of `rx_ctrl`) and `locked` becomes 1.
- R7: With offset m, number the eight symbols of the previous and current input words 0 to 7, with the previous word's lanes 0..3 first. Output lane k then carries symbol m+k, data and control flag together. The result is registered, so after the edge that samples input word N+1, the outputs hold the word rebuilt from words N and N+1.
- R8: After each edge, `out_valid` equals the value of (`locked` and `sync_ok`) sampled at that edge.
- R9: An edge that samples `sync_ok` = 0 clears `locked` and leaves `offset` unchanged.
- R10: While `align_en` is 0, markers do not change `offset`. A marker seen after `align_en` is raised again replaces it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_data | input | 32 | Received word, lane l in bits 8l+7..8l |
| rx_ctrl | input | 4 | Control-character flag per received lane |
| sync_ok | input | 1 | Upstream symbol-alignment sync status |
| align_en | input | 1 | Manual enable that arms the marker search |
| out_data | output | 32 | Reordered word |
| out_ctrl | output | 4 | Control flags travelling with the reordered bytes |
| out_valid | output | 1 | Output word is from a locked alignment |
| locked | output | 1 | Lane offset has been found |
| offset | output | 2 | Stored lane shift |

## Verification
The bench sends an alignment word followed by a stream of data words at every shift from 0 to 3, including the three-lane shift where only one byte of the first word is in the first received word. Each rebuilt word is compared with the transmitted one, so an off-by-one rotation, swapped halves or control flags that stay in their old lanes show up as a wrong word. Other cases cover a 0x1C without its flag and a flagged byte one bit away from the marker, which a loose comparator would lock on. Further cases send markers while sync or the enable is low and two markers in one word, which catch a search that ignores its qualifiers or a highest-lane-first encoder. A sync drop checks that the lock falls while the shift is kept, and a design that cleared the shift would fail there.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    // Search/locked phase of the aligner.
    typedef enum logic {
        PH_SEARCH = 1'b0,
        PH_LOCKED = 1'b1
    } phase_e;

    // Default marker byte (sent with its control flag set).
    localparam logic [7:0] DEFAULT_MARKER = 8'h1C;

endpackage

// File: rtl/marker_finder.sv
module marker_finder #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned SYM_W  = 8,
    parameter logic [SYM_W-1:0] MARKER = 8'h1C,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  logic [LANES*SYM_W-1:0] word_data,
    input  logic [LANES-1:0]       word_ctrl,
    output logic                   hit,
    output logic [OFF_W-1:0]       hit_lane
);

    logic [LANES-1:0] lane_match;

    // One comparator per lane: the flag must be set and the byte must equal the marker.
    for (genvar l = 0; l < LANES; l++) begin : g_cmp
        assign lane_match[l] = word_ctrl[l] && (word_data[l*SYM_W +: SYM_W] == MARKER);
    end

    // Priority encoder: scan downward so that the lowest matching lane is written last.
    always_comb begin
        hit      = 1'b0;
        hit_lane = '0;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (lane_match[l]) begin
                hit      = 1'b1;
                hit_lane = OFF_W'(l);
            end
        end
    end

endmodule

// File: rtl/lane_rotator.sv
module lane_rotator #(
    parameter int unsigned LANES = 4,
    parameter int unsigned SYM_W = 8,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned W     = LANES * SYM_W
) (
    input  logic [W-1:0]       cur_data,
    input  logic [LANES-1:0]   cur_ctrl,
    input  logic [W-1:0]       prev_data,
    input  logic [LANES-1:0]   prev_ctrl,
    input  logic [OFF_W-1:0]   shift,
    output logic [W-1:0]       rot_data,
    output logic [LANES-1:0]   rot_ctrl
);

    // Eight-symbol window: previous word in the low half, current word above it.
    logic [2*W-1:0]     win_data;
    logic [2*LANES-1:0] win_ctrl;

    assign win_data = {cur_data, prev_data};
    assign win_ctrl = {cur_ctrl, prev_ctrl};

    // Each output lane picks window symbol shift+k; the flag uses the same index as its byte.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [OFF_W:0] src;
        assign src = {1'b0, shift} + (OFF_W + 1)'(k);
        assign rot_data[k*SYM_W +: SYM_W] = win_data[src*SYM_W +: SYM_W];
        assign rot_ctrl[k]                = win_ctrl[src];
    end

endmodule

// File: rtl/byte_lane_aligner.sv
module byte_lane_aligner
    import lane_align_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned SYM_W = 8,
    parameter logic [SYM_W-1:0] MARKER = DEFAULT_MARKER,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned W     = LANES * SYM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [W-1:0]       rx_data,
    input  logic [LANES-1:0]   rx_ctrl,
    input  logic               sync_ok,
    input  logic               align_en,
    output logic [W-1:0]       out_data,
    output logic [LANES-1:0]   out_ctrl,
    output logic               out_valid,
    output logic               locked,
    output logic [OFF_W-1:0]   offset
);

    typedef struct packed {
        phase_e             phase;
        logic [OFF_W-1:0]   shift;
        logic [W-1:0]       prev_data;
        logic [LANES-1:0]   prev_ctrl;
        logic [W-1:0]       out_data;
        logic [LANES-1:0]   out_ctrl;
        logic               out_valid;
    } state_t;

    state_t st_d, st_q;

    logic               hit;
    logic [OFF_W-1:0]   hit_lane;
    logic [W-1:0]       rot_data;
    logic [LANES-1:0]   rot_ctrl;

    marker_finder #(
        .LANES  (LANES),
        .SYM_W  (SYM_W),
        .MARKER (MARKER)
    ) u_find (
        .word_data (rx_data),
        .word_ctrl (rx_ctrl),
        .hit       (hit),
        .hit_lane  (hit_lane)
    );

    lane_rotator #(
        .LANES (LANES),
        .SYM_W (SYM_W)
    ) u_rot (
        .cur_data  (rx_data),
        .cur_ctrl  (rx_ctrl),
        .prev_data (st_q.prev_data),
        .prev_ctrl (st_q.prev_ctrl),
        .shift     (st_q.shift),
        .rot_data  (rot_data),
        .rot_ctrl  (rot_ctrl)
    );

    always_comb begin
        st_d = st_q;

        // One-word history for the rotator.
        st_d.prev_data = rx_data;
        st_d.prev_ctrl = rx_ctrl;

        // Registered output stage.
        st_d.out_data  = rot_data;
        st_d.out_ctrl  = rot_ctrl;
        st_d.out_valid = (st_q.phase == PH_LOCKED) && sync_ok;

        // Lock control: sync loss drops the lock, an armed hit (re)takes it.
        if (!sync_ok) begin
            st_d.phase = PH_SEARCH;
        end else if (align_en && hit) begin
            st_d.phase = PH_LOCKED;
            st_d.shift = hit_lane;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_data  = st_q.out_data;
    assign out_ctrl  = st_q.out_ctrl;
    assign out_valid = st_q.out_valid;
    assign locked    = (st_q.phase == PH_LOCKED);
    assign offset    = st_q.shift;

endmodule

// File: rtl/byte_lane_aligner_chk.sv
module byte_lane_aligner_chk #(
    parameter int unsigned SYM_W  = 8,
    parameter int unsigned OFF_W  = 2,
    parameter logic [SYM_W-1:0] MARKER = 8'h1C
) (
    input logic               clk,
    input logic               rst,
    input logic [SYM_W-1:0]   lane0_data,
    input logic               lane0_ctrl,
    input logic               sync_ok,
    input logic               align_en,
    input logic               out_valid,
    input logic               locked,
    input logic [OFF_W-1:0]   offset
);

    // R3
    lock_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_ok |=> !locked);

    // R4
    rise_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(sync_ok && align_en));

    // R6
    lane0_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_ok && align_en && lane0_ctrl && lane0_data == MARKER) |=> (locked && offset == '0));

    // R8
    valid_follows_lock_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(locked && sync_ok));

    // R9
    shift_kept_nosync_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_ok |=> $stable(offset));

    // R10
    shift_kept_noarm_chk: assert property (@(posedge clk) disable iff (rst)
        !align_en |=> $stable(offset));

endmodule

bind byte_lane_aligner byte_lane_aligner_chk #(
    .SYM_W  (SYM_W),
    .OFF_W  (OFF_W),
    .MARKER (MARKER)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lane0_data (rx_data[SYM_W-1:0]),
    .lane0_ctrl (rx_ctrl[0]),
    .sync_ok    (sync_ok),
    .align_en   (align_en),
    .out_valid  (out_valid),
    .locked     (locked),
    .offset     (offset)
);

// File: tb/sim_byte_lane_aligner.sv
`timescale 1ns/1ps
module sim_byte_lane_aligner;

    localparam int NW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_data = '0;
    logic [3:0]  rx_ctrl = '0;
    logic        sync_ok = 1'b0;
    logic        align_en = 1'b0;
    logic [31:0] out_data;
    logic [3:0]  out_ctrl;
    logic        out_valid;
    logic        locked;
    logic [1:0]  offset;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    byte_lane_aligner u0 (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .sync_ok(sync_ok), .align_en(align_en), .out_data(out_data),
        .out_ctrl(out_ctrl), .out_valid(out_valid), .locked(locked), .offset(offset)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Transmitted symbol {flag, byte}: word 0 is the alignment word.
    function automatic logic [8:0] tx_sym(int j, int b, int seed, int m);
        logic [7:0] d;
        if (j == 0) begin
            if (b == 0) return {1'b1, 8'h1C};
            if (b == 1) return {1'b1, 8'hBC};
            return 9'h000;
        end
        d = 8'((seed * 37 + j * 29 + b * 13 + m * 7 + 3) & 255);
        return {((j + b + seed) % 3 == 0) ? 1'b1 : 1'b0, d};
    endfunction

    // Received symbol: the byte stream is delayed by m lanes, filler in front.
    function automatic logic [8:0] rx_sym(int i, int l, int m, int seed);
        int p;
        p = 4 * i + l - m;
        if (p < 0) return {1'b0, 8'h55};
        return tx_sym(p / 4, p % 4, seed, m);
    endfunction

    task automatic put(input logic [31:0] d, input logic [3:0] c, input logic s, input logic e);
        @(negedge clk);
        rx_data = d; rx_ctrl = c; sync_ok = s; align_en = e;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rx_data = '0; rx_ctrl = '0; sync_ok = 1'b0; align_en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        logic [31:0] d, ed;
        logic [3:0]  c, ec;
        logic [8:0]  s;

        do_reset();
        // R1 reset state
        chk("R1", "locked", locked, 0);
        chk("R1", "offset", offset, 0);
        chk("R1", "out_valid", out_valid, 0);

        // R7/R8/R6/R9 sweep over every shift and two data patterns
        for (int seed = 0; seed < 2; seed++) begin
            for (int m = 0; m < 4; m++) begin
                do_reset();
                for (int i = 0; i <= NW; i++) begin
                    for (int l = 0; l < 4; l++) begin
                        s = rx_sym(i, l, m, seed);
                        d[l*8 +: 8] = s[7:0];
                        c[l] = s[8];
                    end
                    put(d, c, 1'b1, (i == 0));
                    if (i == 0) begin
                        chk("R6", "locked after marker", locked, 1);
                        chk("R6", "offset after marker", offset, 64'(m));
                        chk("R8", "valid before lock", out_valid, 0);
                    end else begin
                        for (int l = 0; l < 4; l++) begin
                            s = tx_sym(i - 1, l, seed, m);
                            ed[l*8 +: 8] = s[7:0];
                            ec[l] = s[8];
                        end
                        chk("R7", "rebuilt data", out_data, ed);
                        chk("R7", "rebuilt flags", out_ctrl, ec);
                        chk("R8", "valid while locked", out_valid, 1);
                    end
                end
                // R9 sync loss drops lock, keeps shift
                put(32'h0, 4'h0, 1'b0, 1'b0);
                chk("R9", "locked after sync loss", locked, 0);
                chk("R9", "offset after sync loss", offset, 64'(m));
                chk("R8", "valid at sync loss", out_valid, 0);
                put(32'h0, 4'h0, 1'b1, 1'b0);
                chk("R8", "valid after sync loss", out_valid, 0);
            end
        end

        // R3 marker with sync low
        do_reset();
        put(32'h0000_BC1C, 4'b0011, 1'b0, 1'b1);
        chk("R3", "no lock without sync", locked, 0);
        put(32'h0000_0000, 4'b0000, 1'b1, 1'b0);
        chk("R3", "valid stays low", out_valid, 0);

        // R4 marker with enable low
        put(32'h0000_BC1C, 4'b0011, 1'b1, 1'b0);
        chk("R4", "no lock without enable", locked, 0);

        // R2 near-miss symbols
        put(32'h9C1D_BC1C, 4'b1110, 1'b1, 1'b1);
        chk("R2", "no lock on near-miss", locked, 0);
        chk("R2", "offset untouched", offset, 0);

        // R5 two markers: lanes 1 and 3
        put(32'h1C00_1C00, 4'b1010, 1'b1, 1'b1);
        chk("R5", "locked", locked, 1);
        chk("R5", "lowest lane wins", offset, 1);
        put(32'h1C1C_0000, 4'b1100, 1'b1, 1'b1);
        chk("R5", "lanes 2 and 3", offset, 2);

        // R10 marker ignored while enable low, accepted once re-armed
        put(32'h1C00_0000, 4'b1000, 1'b1, 1'b0);
        chk("R10", "offset held", offset, 2);
        chk("R10", "still locked", locked, 1);
        put(32'h1C00_0000, 4'b1000, 1'b1, 1'b1);
        chk("R10", "re-armed offset", offset, 3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule